// File: doc/BRIEF.md
# Watchdog Timer with Early Warning

This block is a watchdog timer for a large chip. A fixed divide-by-4 prescaler feeds a 24-bit down-counter. Software loads a reload value, enables the watchdog, and must then service it with a two-write feed sequence before the counter runs out. When the counter expires, or when a feed sequence is malformed, the block raises a fault event. Depending on the mode that was in force at the last valid feed, the event becomes a one-cycle reset request to the chip reset controller or a level interrupt. An early warning interrupt fires when the count passes a programmable compare value. The oscillator and the reset controller are outside this block.

Software reaches the block through a simple single-cycle register bus. The bus has a select, a write strobe, an address, write data and combinational read data. It has no back-pressure: every selected cycle is one complete access. All other pins are plain control and status lines. Register addresses are: 0 control/status, 1 reload, 2 feed, 3 current count (read only), 4 warning compare. The control/status word holds five bits. Bit 0 is enable, bit 1 is reset mode, bit 2 is the timeout flag, bit 3 is the warning flag, and bit 4 shows that the counter is running.

Top module: `wdt_timer`

## Requirements
- R1: After reset, the control/status word reads 0, the count register reads 0xFF, and rst_req, to_irq and warn_irq are low.
- R2: A reload write below 0xFF stores 0xFF. Any other value is stored unchanged.
- R3: Writing 1 to control bit 0 sets enable, and writing 0 leaves it set. Writing 1 to control bit 1 sets reset mode, and only a reset clears it.
- R4: While enabled, a valid feed is a write of 0xAA to the feed register followed, at the very next bus access, by a write of 0x55. It loads the count from the reload register and starts the counter. Feed writes while the watchdog is disabled have no effect.
- R5: The count drops by one every 4 clocks. The first decrement comes 4 clocks after the valid feed. Expiry happens 4×(reload+1) clocks after the edge of the feed write.
- R6: An event under reset mode gives a single-cycle rst_req pulse and sets the timeout flag (bit 2).
- R7: An event under interrupt mode sets the timeout flag and raises to_irq. to_irq stays high until bit 2 is cleared, and no rst_req is given.
- R8: A change to reload value or mode takes effect only at the next valid feed.
- R9: While enabled, any of these is an immediate event: a feed write whose value is not the expected key, a 0x55 without a preceding 0xAA, or any other access between 0xAA and 0x55.
- R10: When a counter tick finds the count equal to the warning compare value, the warning flag (bit 3) is set and warn_irq goes high.
- R11: Writing 1 to bit 2 or bit 3 clears that flag. Writing 0 has no effect.
- R12: An event clears enable and the running bit. After that the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Read data (combinational) |
| rst_req | output | 1 | One-cycle reset request |
| to_irq | output | 1 | Timeout interrupt (level) |
| warn_irq | output | 1 | Early warning interrupt (level) |

## Verification
The hardest case to reach is a mode or reload change made while the counter is running. The change must stay dormant until the next feed, so the bench edits both registers mid-count and then lets the old settings expire. The bench also produces each malformed-feed shape on purpose, including a read that lands between the two keys. A scoreboard holds the exact cycle of every expected rst_req pulse, to_irq rise and warn_irq rise, and checks each one against what the design does.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 24;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd1;
  localparam logic [ADDR_W-1:0] A_FEED   = 3'd2;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_WARN   = 3'd4;
  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam int B_EN = 0;
  localparam int B_MODE = 1;
  localparam int B_TOF = 2;
  localparam int B_WARN = 3;
  localparam int B_RUN = 4;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else if (clr || !run) phase <= '0;
    else if (phase == LAST) phase <= '0;
    else phase <= phase + 1'b1;
  end

  assign tick = run && !clr && (phase == LAST);

  // R5: ticks never come back to back
  a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/wdt_feed_chk.sv
module wdt_feed_chk
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              acc,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output logic              feed_ok,
  output logic              feed_bad
);
  logic armed;
  logic is_feed_wr;

  assign is_feed_wr = acc && we && (addr == A_FEED);

  always_comb begin
    feed_ok  = 1'b0;
    feed_bad = 1'b0;
    if (en && acc) begin
      if (armed) begin
        if (is_feed_wr && data == KEY_SECOND) feed_ok = 1'b1;
        else feed_bad = 1'b1;
      end else if (is_feed_wr && data != KEY_FIRST) begin
        feed_bad = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else if (!en) armed <= 1'b0;
    else if (acc) armed <= !armed && is_feed_wr && (data == KEY_FIRST);
  end

  // R9: a feed never completes and faults at once
  a_r9_ok_bad_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(feed_ok && feed_bad));
  // R4: a completed sequence clears the armed state
  a_r4_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    feed_ok |=> !armed);
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int CW = 24,
  parameter int WW = 10,
  parameter logic [CW-1:0] RST_VAL = CW'(255)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] reload,
  input  logic          run,
  input  logic          tick,
  input  logic [WW-1:0] warn_cmp,
  output logic [CW-1:0] count,
  output logic          expire,
  output logic          warn_hit
);
  logic step;
  assign step = run && tick && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= RST_VAL;
    else if (load) count <= reload;
    else if (step && count != '0) count <= count - 1'b1;
  end

  assign expire   = step && (count == '0);
  assign warn_hit = step && (count == CW'(warn_cmp));

  // R12: without a tick or load the count holds
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(count));
  // R4: load takes the reload value
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(reload));
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int CW = 24,
  parameter int WW = 10,
  parameter int DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req,
  output logic              to_irq,
  output logic              warn_irq
);
  localparam logic [CW-1:0] MIN_RELOAD = CW'(255);

  logic en, mode, act_mode, active, tof, warnf, intp;
  logic [CW-1:0] reload_q, count;
  logic [WW-1:0] warn_cmp;
  logic tick, expire, warn_hit, feed_ok, feed_bad, fault, eff_mode;
  logic wr_ctrl, wr_reload, wr_warn;

  assign wr_ctrl   = bus_sel && bus_we && bus_addr == A_CTRL;
  assign wr_reload = bus_sel && bus_we && bus_addr == A_RELOAD;
  assign wr_warn   = bus_sel && bus_we && bus_addr == A_WARN;
  assign fault     = expire || feed_bad;
  assign eff_mode  = active ? act_mode : mode;

  wdt_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(active), .clr(feed_ok), .tick(tick));

  wdt_feed_chk u_feed (
    .clk(clk), .rst_n(rst_n), .en(en), .acc(bus_sel), .we(bus_we),
    .addr(bus_addr), .data(bus_wdata[7:0]),
    .feed_ok(feed_ok), .feed_bad(feed_bad));

  wdt_count #(.CW(CW), .WW(WW), .RST_VAL(MIN_RELOAD)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(feed_ok), .reload(reload_q),
    .run(active), .tick(tick), .warn_cmp(warn_cmp),
    .count(count), .expire(expire), .warn_hit(warn_hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0;
      mode <= 1'b0;
      act_mode <= 1'b0;
      active <= 1'b0;
      tof <= 1'b0;
      warnf <= 1'b0;
      intp <= 1'b0;
      rst_req <= 1'b0;
      reload_q <= MIN_RELOAD;
      warn_cmp <= '0;
    end else begin
      if (fault) en <= 1'b0;
      else if (wr_ctrl && bus_wdata[B_EN]) en <= 1'b1;
      if (wr_ctrl && bus_wdata[B_MODE]) mode <= 1'b1;
      if (feed_ok) act_mode <= mode;
      if (fault) active <= 1'b0;
      else if (feed_ok) active <= 1'b1;
      if (fault) tof <= 1'b1;
      else if (wr_ctrl && bus_wdata[B_TOF]) tof <= 1'b0;
      if (fault && !eff_mode) intp <= 1'b1;
      else if (wr_ctrl && bus_wdata[B_TOF]) intp <= 1'b0;
      if (warn_hit) warnf <= 1'b1;
      else if (wr_ctrl && bus_wdata[B_WARN]) warnf <= 1'b0;
      rst_req <= fault && eff_mode;
      if (wr_reload)
        reload_q <= (CW'(bus_wdata) < MIN_RELOAD) ? MIN_RELOAD : CW'(bus_wdata);
      if (wr_warn) warn_cmp <= WW'(bus_wdata);
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[B_EN]   = en;
        bus_rdata[B_MODE] = mode;
        bus_rdata[B_TOF]  = tof;
        bus_rdata[B_WARN] = warnf;
        bus_rdata[B_RUN]  = active;
      end
      A_RELOAD: bus_rdata = DATA_W'(reload_q);
      A_COUNT:  bus_rdata = DATA_W'(count);
      A_WARN:   bus_rdata = DATA_W'(warn_cmp);
      default:  bus_rdata = '0;
    endcase
  end

  assign to_irq   = intp;
  assign warn_irq = warnf;

  // R3: enable stays set unless an event occurs
  a_r3_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !expire && !feed_bad) |=> en);
  // R6: reset request lasts a single cycle
  a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R2: stored reload never below the minimum
  a_r2_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    reload_q >= MIN_RELOAD);
  // R12: an event stops the counter
  a_r12_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (expire || feed_bad) |=> (!active && !en));
endmodule

// File: tb/sim_wdt_timer.sv
module sim_wdt_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [23:0] bus_wdata = '0;
  logic [23:0] bus_rdata;
  logic rst_req, to_irq, warn_irq;

  always #2 clk = ~clk;

  wdt_timer u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_req(rst_req), .to_irq(to_irq), .warn_irq(warn_irq));

  typedef struct { int kind; int cyc; string req; } exp_t;
  exp_t sb[$];
  int cyc = 0;
  int nchk = 0, nfail = 0;
  logic done = 1'b0;
  logic p_irq = 1'b0, p_warn = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push(input int kind, input int c, input string req);
    exp_t e;
    e.kind = kind; e.cyc = c; e.req = req;
    sb.push_back(e);
  endtask

  // monitor: kind 0 reset pulse, 1 timeout irq rise, 2 warning rise
  always @(negedge clk) begin
    if (rst_n) begin
      if (rst_req) pop_cmp(0);
      if (to_irq && !p_irq) pop_cmp(1);
      if (warn_irq && !p_warn) pop_cmp(2);
    end
    p_irq <= to_irq;
    p_warn <= warn_irq;
  end

  task automatic pop_cmp(input int kind);
    exp_t e;
    if (sb.size() == 0) begin
      chk(1'b0, "R6/R7/R10 unexpected event", kind, -1);
    end else begin
      e = sb.pop_front();
      chk(e.kind == kind && e.cyc == cyc, e.req, kind * 100000 + cyc,
          e.kind * 100000 + e.cyc);
    end
  endtask

  // all tasks are entered and left at a falling edge
  task automatic wr(input logic [2:0] a, input logic [23:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [23:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic feed(output int n);
    wr(3'd2, 24'hAA);
    wr(3'd2, 24'h55);
    n = cyc;
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    logic [23:0] v, v2;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    rd(3'd0, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(3'd3, v); chk(v == 24'hFF, "R1 count", v, 24'hFF);
    chk(!rst_req && !to_irq && !warn_irq, "R1 outputs", {rst_req, to_irq, warn_irq}, 0);
    // R2
    wr(3'd1, 24'h10); rd(3'd1, v); chk(v == 24'hFF, "R2 clamp", v, 24'hFF);
    wr(3'd1, 24'h120); rd(3'd1, v); chk(v == 24'h120, "R2 keep", v, 24'h120);
    // R4 feed while disabled is ignored
    feed(n);
    rd(3'd3, v); chk(v == 24'hFF, "R4 disabled feed", v, 24'hFF);
    rd(3'd0, v); chk(v == 0, "R4 disabled ctrl", v, 0);
    // R3 enable sticky
    wr(3'd0, 24'h1); wr(3'd0, 24'h0);
    rd(3'd0, v); chk(v == 24'h1, "R3 enable sticky", v, 1);
    // R10 R5 R7 R8 interrupt-mode run
    wr(3'd4, 24'h100);
    feed(n);
    push(2, n + 4 * (24'h120 - 24'h100 + 1), "R10 warning cycle");
    push(1, n + 4 * (24'h120 + 1), "R7 R8 R5 expiry cycle");
    rd(3'd3, v); chk(v == 24'h120, "R4 load", v, 24'h120);
    wait_to(n + 9);
    rd(3'd3, v); chk(v == 24'h11E, "R5 decrement rate", v, 24'h11E);
    wr(3'd1, 24'h200); // R8: not used until the next feed
    wait_to(n + 4 * 24'h121 + 4);
    rd(3'd0, v); chk(v == 24'h0C, "R12 R7 ctrl after event", v, 24'h0C);
    chk(to_irq && !rst_req, "R7 irq level", to_irq, 1);
    rd(3'd3, v); repeat (10) @(negedge clk); rd(3'd3, v2);
    chk(v == v2, "R12 count holds", v2, v);
    // R11
    wr(3'd0, 24'h0); rd(3'd0, v); chk(v == 24'h0C, "R11 zero no effect", v, 24'h0C);
    wr(3'd0, 24'h8); rd(3'd0, v); chk(v == 24'h04 && !warn_irq, "R11 clear warn", v, 24'h04);
    wr(3'd0, 24'h4); rd(3'd0, v); chk(v == 0 && !to_irq, "R11 clear tof", v, 0);
    // R8 mode change waits for feed
    wr(3'd1, 24'h100); wr(3'd4, 24'h3FF);
    wr(3'd0, 24'h1);
    feed(n);
    push(1, n + 4 * 257, "R8 mode change deferred");
    wr(3'd0, 24'h3);
    wait_to(n + 4 * 257 + 3);
    wr(3'd0, 24'hC);
    rd(3'd0, v); chk(v == 24'h02, "R3 mode sticky", v, 2);
    // R6 reset mode with keep-alive feed
    wr(3'd0, 24'h1);
    feed(n);
    wait_to(n + 600);
    feed(n);
    push(0, n + 4 * 257, "R6 R4 reset after refeed");
    wait_to(n + 4 * 257 + 3);
    rd(3'd0, v); chk(v == 24'h06, "R6 ctrl", v, 6);
    wr(3'd0, 24'h4);
    // R9 access between the keys
    wr(3'd0, 24'h1); feed(n);
    wr(3'd2, 24'hAA);
    push(0, cyc + 1, "R9 access between keys");
    rd(3'd3, v);
    repeat (2) @(negedge clk);
    rd(3'd0, v); chk(v == 24'h06, "R9 fault flags", v, 6);
    wr(3'd0, 24'h4);
    // R9 wrong key value
    wr(3'd0, 24'h1); feed(n);
    push(0, cyc + 1, "R9 wrong key");
    wr(3'd2, 24'h12);
    repeat (2) @(negedge clk);
    wr(3'd0, 24'h4);
    // R9 second key alone
    wr(3'd0, 24'h1);
    push(0, cyc + 1, "R9 lone second key");
    wr(3'd2, 24'h55);
    repeat (20) @(negedge clk);
    chk(sb.size() == 0, "R6 R7 R10 all events seen", sb.size(), 0);
    done = 1'b1;
  end

  initial begin
    while (!done && cyc < 100000) @(negedge clk);
    if (!done) chk(1'b0, "watchdog", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule